// File: doc/BRIEF.md
# Switch Soft-Reset Sequencer

This block brings a multi-port switch through a controlled software reset. It drives a simple internal register bus as its only master. A start pulse launches the sequence. The block first takes every port out of service by rewriting the two-bit state field in that port's control register. Next it holds the bus idle for a fixed drain interval, so that queued traffic can leave. It then sets a self-clearing reset bit in the global control register and polls that bit once per millisecond until the switch clears it or the poll budget runs out.

A one-cycle done pulse ends every sequence, and a status code says how it ended: completed, timed out, or aborted on a bus error. The number of ports to quiesce is sampled from an input at start, because the same block serves switch families with different port counts. A clock divider produces the millisecond time base. Its ratio is a parameter, so the drain delay and the poll spacing are exact cycle counts.

Bus handshake: the block holds `bus_req` and every request field steady until the responder pulses `bus_ack` for one cycle. `bus_rdata` and `bus_err` are valid only in that ack cycle.

Top module: `swrst_sequencer`

## Requirements
- R1: A `start` pulse while `busy` is low begins a sequence. A `start` pulse while `busy` is high has no effect: there is no second done pulse, no extra bus transaction, and the port count is not re-sampled.
- R2: Ports 0 to N-1 are handled in ascending order. Each port gets a read and then a write of register offset 4 at device address `PORT_BASE`+i. The written value is the value read with bits 1:0 (the state field) forced to 0, which means disabled. Every other bit keeps its read value. All port traffic ends before the first global access.
- R3: A `port_count` above `MAX_PORTS` (default 11) is treated as `MAX_PORTS`. A `port_count` of 0 skips the port pass. Ports at or above the effective count are never accessed.
- R4: After the last port write is acknowledged, the bus stays idle for exactly `DRAIN_MS`×`TICK_DIV` cycles. The block then reads the global control register (device `GLOBAL_DEV`, offset 4).
- R5: The global control register is rewritten with the value just read, with bit 15 set and every other bit unchanged.
- R6: After the trigger write, the block reads the global control register repeatedly. Consecutive reads are separated by exactly `TICK_DIV` idle cycles. The first read with bit 15 equal to 0 ends the sequence with status 2'b00 (ok).
- R7: If `POLL_MAX` (default 1000) consecutive polls all return bit 15 set, the sequence ends with status 2'b01 (timeout) and no further read is issued.
- R8: A bus transaction acknowledged with `bus_err` aborts the sequence at once. The block issues no further request and ends with status 2'b10 (bus error).
- R9: `busy` is high from the cycle after an accepted start until the done cycle. `done` is high for exactly one cycle and never together with `busy`. While a request waits for its ack, the request fields do not change.
- R10: After reset, `busy`, `done` and `bus_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that begins a sequence |
| port_count | input | CNT_W (4) | Number of ports to disable, sampled at start |
| bus_req | output | 1 | Register transaction pending |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_dev | output | ADDR_W (5) | Device address of the transaction |
| bus_reg | output | REG_W (5) | Register offset of the transaction |
| bus_wdata | output | DATA_W (16) | Write data |
| bus_ack | input | 1 | One-cycle completion from the responder |
| bus_err | input | 1 | Error flag, valid with bus_ack |
| bus_rdata | input | DATA_W (16) | Read data, valid with bus_ack |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| status | output | 2 | Result: 00 ok, 01 timeout, 10 bus error; held until the next done |

## Verification
The bench targets the poll budget edges. A switch that clears the bit on poll 1000 must finish ok, and one that clears it on poll 1001 must time out after exactly 1000 reads. An off-by-one counter gives the wrong status or a wrong read count. The responder models port registers with random contents, so the bench can detect a read-modify-write that clobbers neighbouring bits, a port skipped or visited out of order, a count of 0 that still touches ports, or a count of 15 that runs past port 10. Bus errors are injected on the first read, a mid-pass port write, the trigger write and a poll read. A design that keeps going after an error shows up as extra transactions or modified ports. A restart pulse in mid-run would show up as a second done or re-sampled ports. The idle gaps before the global read and between polls are measured in cycles, which catches a divider or drain counter that is one tick short or long.

// File: rtl/swrst_pkg.sv
// Shared types for the switch soft-reset sequencer.
package swrst_pkg;

    // Result code reported with the done pulse.
    typedef enum logic [1:0] {
        ST_OK      = 2'b00,
        ST_TIMEOUT = 2'b01,
        ST_BUSERR  = 2'b10
    } swrst_status_e;

    // Sequencer phases.
    typedef enum logic [3:0] {
        S_IDLE,
        S_PORT_RD,
        S_PORT_WR,
        S_DRAIN,
        S_GLB_RD,
        S_GLB_WR,
        S_POLL,
        S_POLL_WAIT,
        S_FIN
    } swrst_state_e;

endpackage

// File: rtl/swrst_tick.sv
// Millisecond time base.
// Emits a one-cycle tick every TICK_DIV cycles, counted from the cycle after
// clr drops. While clr is high the counter holds at zero and no tick is emitted.
// Assumes TICK_DIV >= 1.
module swrst_tick #(
    parameter int unsigned TICK_DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt;

    // Divider counter: restarts on clear or when it wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = !clr && (cnt == LAST);
endmodule

// File: rtl/swrst_rmw.sv
// Modify stage of the read-modify-write accesses.
// In port mode it replaces the state field with the disabled value.
// In trigger mode it sets the reset bit. All other bits pass through.
// Purely combinational.
module swrst_rmw #(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned FIELD_LSB = 0,
    parameter int unsigned FIELD_W   = 2,
    parameter int unsigned FIELD_VAL = 0,
    parameter int unsigned TRIG_BIT  = 15
) (
    input  logic [DATA_W-1:0] rd_data,
    input  logic              sel_trig,
    output logic [DATA_W-1:0] wr_data
);
    localparam logic [DATA_W-1:0] FIELD_MASK =
        ((DATA_W'(1) << FIELD_W) - DATA_W'(1)) << FIELD_LSB;
    localparam logic [DATA_W-1:0] FIELD_SET =
        (DATA_W'(FIELD_VAL) << FIELD_LSB) & FIELD_MASK;
    localparam logic [DATA_W-1:0] TRIG_MASK = DATA_W'(1) << TRIG_BIT;

    // Choose between the port-disable merge and the reset-bit set.
    always_comb begin
        if (sel_trig) begin
            wr_data = rd_data | TRIG_MASK;
        end else begin
            wr_data = (rd_data & ~FIELD_MASK) | FIELD_SET;
        end
    end
endmodule

// File: rtl/swrst_seq.sv
// Control FSM of the soft-reset sequencer.
// It runs the port pass, the drain wait, the reset trigger and the polling.
// Assumes a responder that answers each request with a single-cycle ack
// (with err and rdata valid in that cycle), and a tick source that holds
// while tick_clr is high.
module swrst_seq
    import swrst_pkg::*;
#(
    parameter int unsigned MAX_PORTS  = 11,
    parameter int unsigned CNT_W      = 4,
    parameter int unsigned ADDR_W     = 5,
    parameter int unsigned REG_W      = 5,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned PORT_BASE  = 16,
    parameter int unsigned GLOBAL_DEV = 27,
    parameter int unsigned CTRL_REG   = 4,
    parameter int unsigned TRIG_BIT   = 15,
    parameter int unsigned DRAIN_MS   = 2,
    parameter int unsigned POLL_MAX   = 1000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CNT_W-1:0]    port_count,
    input  logic                tick,
    output logic                tick_clr,
    output logic                bus_req,
    output logic                bus_we,
    output logic [ADDR_W-1:0]   bus_dev,
    output logic [REG_W-1:0]    bus_reg,
    input  logic                bus_ack,
    input  logic                bus_err,
    input  logic [DATA_W-1:0]   bus_rdata,
    output logic [DATA_W-1:0]   hold_data,
    output logic                rmw_trig,
    output logic                busy,
    output logic                done,
    output swrst_status_e       status
);
    localparam int unsigned PIDX_W = $clog2(MAX_PORTS + 1);
    localparam int unsigned DC_W   = $clog2(DRAIN_MS + 1);
    localparam int unsigned PC_W   = $clog2(POLL_MAX + 1);
    localparam logic [PIDX_W-1:0] MAX_IDX = PIDX_W'(MAX_PORTS);
    localparam logic [DC_W-1:0]   DC_LAST = DC_W'(DRAIN_MS - 1);
    localparam logic [PC_W-1:0]   PC_LAST = PC_W'(POLL_MAX - 1);

    swrst_state_e        state;
    logic [PIDX_W-1:0]   port_idx;
    logic [PIDX_W-1:0]   port_last;
    logic [PIDX_W-1:0]   eff_cnt;
    logic [DATA_W-1:0]   hold;
    logic [DC_W-1:0]     drain_cnt;
    logic [PC_W-1:0]     poll_cnt;
    swrst_status_e       status_q;
    logic                port_phase;

    // Clamp the requested port count to the number of ports that exist.
    always_comb begin
        if (int'(port_count) > int'(MAX_PORTS)) begin
            eff_cnt = MAX_IDX;
        end else begin
            eff_cnt = PIDX_W'(port_count);
        end
    end

    // Sequence state, port walk, drain and poll counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            port_idx  <= '0;
            port_last <= '0;
            hold      <= '0;
            drain_cnt <= '0;
            poll_cnt  <= '0;
            status_q  <= ST_OK;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        port_idx <= '0;
                        if (eff_cnt == '0) begin
                            state <= S_DRAIN;
                        end else begin
                            port_last <= eff_cnt - 1'b1;
                            state     <= S_PORT_RD;
                        end
                    end
                end
                S_PORT_RD: begin
                    if (bus_ack) begin
                        if (bus_err) begin
                            status_q <= ST_BUSERR;
                            state    <= S_FIN;
                        end else begin
                            hold  <= bus_rdata;
                            state <= S_PORT_WR;
                        end
                    end
                end
                S_PORT_WR: begin
                    if (bus_ack) begin
                        if (bus_err) begin
                            status_q <= ST_BUSERR;
                            state    <= S_FIN;
                        end else if (port_idx == port_last) begin
                            state <= S_DRAIN;
                        end else begin
                            port_idx <= port_idx + 1'b1;
                            state    <= S_PORT_RD;
                        end
                    end
                end
                S_DRAIN: begin
                    if (tick) begin
                        if (drain_cnt == DC_LAST) begin
                            drain_cnt <= '0;
                            state     <= S_GLB_RD;
                        end else begin
                            drain_cnt <= drain_cnt + 1'b1;
                        end
                    end
                end
                S_GLB_RD: begin
                    if (bus_ack) begin
                        if (bus_err) begin
                            status_q <= ST_BUSERR;
                            state    <= S_FIN;
                        end else begin
                            hold  <= bus_rdata;
                            state <= S_GLB_WR;
                        end
                    end
                end
                S_GLB_WR: begin
                    if (bus_ack) begin
                        if (bus_err) begin
                            status_q <= ST_BUSERR;
                            state    <= S_FIN;
                        end else begin
                            poll_cnt <= '0;
                            state    <= S_POLL;
                        end
                    end
                end
                S_POLL: begin
                    if (bus_ack) begin
                        if (bus_err) begin
                            status_q <= ST_BUSERR;
                            state    <= S_FIN;
                        end else if (!bus_rdata[TRIG_BIT]) begin
                            status_q <= ST_OK;
                            state    <= S_FIN;
                        end else if (poll_cnt == PC_LAST) begin
                            status_q <= ST_TIMEOUT;
                            state    <= S_FIN;
                        end else begin
                            poll_cnt <= poll_cnt + 1'b1;
                            state    <= S_POLL_WAIT;
                        end
                    end
                end
                S_POLL_WAIT: begin
                    if (tick) begin
                        state <= S_POLL;
                    end
                end
                S_FIN: begin
                    state <= S_IDLE;
                end
                default: begin
                    state <= S_IDLE;
                end
            endcase
        end
    end

    // Bus request fields decoded from the current phase.
    always_comb begin
        port_phase = (state == S_PORT_RD) || (state == S_PORT_WR);
        bus_req    = port_phase || (state == S_GLB_RD) || (state == S_GLB_WR) ||
                     (state == S_POLL);
        bus_we     = (state == S_PORT_WR) || (state == S_GLB_WR);
        bus_dev    = port_phase ? (ADDR_W'(PORT_BASE) + ADDR_W'(port_idx))
                                : ADDR_W'(GLOBAL_DEV);
        bus_reg    = REG_W'(CTRL_REG);
        rmw_trig   = (state == S_GLB_WR);
        hold_data  = hold;
    end

    // Handshake outputs and time-base control.
    always_comb begin
        tick_clr = !((state == S_DRAIN) || (state == S_POLL_WAIT));
        busy     = !((state == S_IDLE) || (state == S_FIN));
        done     = (state == S_FIN);
        status   = status_q;
    end
endmodule

// File: rtl/swrst_sequencer.sv
// Top of the switch soft-reset sequencer.
// Ties together the time base, the control FSM and the modify stage.
// Assumes one responder on the register bus that answers each held request
// with a single-cycle ack. TICK_DIV is the number of clock cycles per millisecond.
module swrst_sequencer
    import swrst_pkg::*;
#(
    parameter int unsigned MAX_PORTS  = 11,
    parameter int unsigned CNT_W      = 4,
    parameter int unsigned ADDR_W     = 5,
    parameter int unsigned REG_W      = 5,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned PORT_BASE  = 16,
    parameter int unsigned GLOBAL_DEV = 27,
    parameter int unsigned CTRL_REG   = 4,
    parameter int unsigned FIELD_LSB  = 0,
    parameter int unsigned FIELD_W    = 2,
    parameter int unsigned FIELD_VAL  = 0,
    parameter int unsigned TRIG_BIT   = 15,
    parameter int unsigned TICK_DIV   = 50000,
    parameter int unsigned DRAIN_MS   = 2,
    parameter int unsigned POLL_MAX   = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  port_count,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_dev,
    output logic [REG_W-1:0]  bus_reg,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status
);
    logic              tick;
    logic              tick_clr;
    logic [DATA_W-1:0] hold_data;
    logic              rmw_trig;
    swrst_status_e     status_e;

    swrst_tick #(
        .TICK_DIV (TICK_DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tick_clr),
        .tick  (tick)
    );

    swrst_seq #(
        .MAX_PORTS  (MAX_PORTS),
        .CNT_W      (CNT_W),
        .ADDR_W     (ADDR_W),
        .REG_W      (REG_W),
        .DATA_W     (DATA_W),
        .PORT_BASE  (PORT_BASE),
        .GLOBAL_DEV (GLOBAL_DEV),
        .CTRL_REG   (CTRL_REG),
        .TRIG_BIT   (TRIG_BIT),
        .DRAIN_MS   (DRAIN_MS),
        .POLL_MAX   (POLL_MAX)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .port_count (port_count),
        .tick       (tick),
        .tick_clr   (tick_clr),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_dev    (bus_dev),
        .bus_reg    (bus_reg),
        .bus_ack    (bus_ack),
        .bus_err    (bus_err),
        .bus_rdata  (bus_rdata),
        .hold_data  (hold_data),
        .rmw_trig   (rmw_trig),
        .busy       (busy),
        .done       (done),
        .status     (status_e)
    );

    swrst_rmw #(
        .DATA_W    (DATA_W),
        .FIELD_LSB (FIELD_LSB),
        .FIELD_W   (FIELD_W),
        .FIELD_VAL (FIELD_VAL),
        .TRIG_BIT  (TRIG_BIT)
    ) u_rmw (
        .rd_data  (hold_data),
        .sel_trig (rmw_trig),
        .wr_data  (bus_wdata)
    );

    assign status = status_e;
endmodule

// File: rtl/swrst_sequencer_chk.sv
// Protocol checker for swrst_sequencer, attached with bind.
// Watches only the top-level ports.
module swrst_sequencer_chk #(
    parameter int unsigned ADDR_W     = 5,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned GLOBAL_DEV = 27,
    parameter int unsigned FIELD_LSB  = 0,
    parameter int unsigned FIELD_W    = 2,
    parameter int unsigned FIELD_VAL  = 0,
    parameter int unsigned TRIG_BIT   = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_dev,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ack,
    input logic              bus_err,
    input logic              busy,
    input logic              done
);
    localparam logic [ADDR_W-1:0]  GDEV = ADDR_W'(GLOBAL_DEV);
    localparam logic [FIELD_W-1:0] FDIS = FIELD_W'(FIELD_VAL);

    // R9: a pending request holds its fields until acknowledged
    a_r9_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_dev) && $stable(bus_we) &&
                                $stable(bus_wdata));

    // R9: done lasts exactly one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: busy and done are never high together
    a_r9_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R10: bus requests only while a sequence runs
    a_r10_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> busy);

    // R8: an errored ack is followed by no request
    a_r8_no_req_after_err: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack && bus_err |=> !bus_req);

    // R5: a global write always carries the reset bit
    a_r5_trig_set: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && (bus_dev == GDEV) |-> bus_wdata[TRIG_BIT]);

    // R2: every port write carries the disabled state
    a_r2_port_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && (bus_dev != GDEV) |->
            bus_wdata[FIELD_LSB +: FIELD_W] == FDIS);
endmodule

bind swrst_sequencer swrst_sequencer_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .GLOBAL_DEV (GLOBAL_DEV),
    .FIELD_LSB  (FIELD_LSB),
    .FIELD_W    (FIELD_W),
    .FIELD_VAL  (FIELD_VAL),
    .TRIG_BIT   (TRIG_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_dev   (bus_dev),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err),
    .busy      (busy),
    .done      (done)
);

// File: tb/swrst_sequencer_bench.sv
`timescale 1ns/1ps
// Bench for swrst_sequencer: a register-bus responder models the port and
// global control registers; runs are directed and seeded-random.
module swrst_sequencer_bench;
    localparam int TD    = 4;
    localparam int DMS   = 2;
    localparam int PMAX  = 1000;
    localparam int NPORT = 11;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [3:0]  port_count;
    logic        bus_req, bus_we;
    logic [4:0]  bus_dev, bus_reg;
    logic [15:0] bus_wdata;
    logic        bus_ack, bus_err;
    logic [15:0] bus_rdata;
    logic        busy, done;
    logic [1:0]  status;

    swrst_sequencer #(
        .TICK_DIV (TD),
        .DRAIN_MS (DMS),
        .POLL_MAX (PMAX)
    ) u_swrst_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .port_count(port_count),
        .bus_req(bus_req), .bus_we(bus_we), .bus_dev(bus_dev), .bus_reg(bus_reg),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_err(bus_err),
        .bus_rdata(bus_rdata), .busy(busy), .done(done), .status(status)
    );

    always #10 clk = ~clk;

    int vectors = 0;
    int fails   = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Responder model state
    logic [15:0] preg  [0:15];
    logic [15:0] pinit [0:15];
    logic [15:0] glb, ginit;
    int cur_eff, clear_after, err_at, lat;
    int txn_n, gstage, polls, exp_port;
    bit exp_pwe;
    int ncyc = 0, wcnt = 0, first_t = 0, last_ack_t = 0;
    bit ack_now = 0, seen = 0;

    // Responder: one-cycle ack after lat waiting cycles; checks order and data
    always @(negedge clk) begin
        ncyc++;
        if (!rst_n) begin
            bus_ack = 0; bus_err = 0; ack_now = 0; seen = 0; wcnt = 0;
        end else if (ack_now) begin
            ack_now = 0; bus_ack = 0; bus_err = 0; seen = 0;
        end else if (bus_req) begin
            if (!seen) begin seen = 1; first_t = ncyc; end
            if (wcnt < lat) begin
                wcnt++;
            end else begin
                int gap;
                wcnt = 0; ack_now = 1; bus_ack = 1; last_ack_t_prev();
                gap = first_t - last_ack_t - 1;
                txn_n++;
                if (txn_n == err_at) begin
                    bus_err = 1; bus_rdata = 16'hDEAD;
                end else if (bus_dev >= 5'd16 && bus_dev < 5'd27) begin
                    int pi;
                    pi = int'(bus_dev) - 16;
                    chk(gstage == 0 && pi == exp_port && bus_we == exp_pwe && bus_reg == 5'd4,
                        "R2 port order/offset", pi, exp_port);
                    if (bus_we) begin
                        chk(bus_wdata == (preg[pi] & 16'hFFFC), "R2 port rmw data",
                            int'(bus_wdata), int'(preg[pi] & 16'hFFFC));
                        preg[pi] = bus_wdata; exp_port++; exp_pwe = 0;
                    end else begin
                        bus_rdata = preg[pi]; exp_pwe = 1;
                    end
                end else if (bus_dev == 5'd27 && bus_reg == 5'd4) begin
                    if (gstage == 0) begin
                        chk(!bus_we, "R5 global read first", int'(bus_we), 0);
                        chk(exp_port == cur_eff && !exp_pwe, "R2 ports done before global",
                            exp_port, cur_eff);
                        if (cur_eff > 0) chk(gap == DMS*TD, "R4 drain gap", gap, DMS*TD);
                        bus_rdata = glb; gstage = 1;
                    end else if (gstage == 1) begin
                        chk(bus_we && bus_wdata == (glb | 16'h8000), "R5 trigger write",
                            int'(bus_wdata), int'(glb | 16'h8000));
                        glb = bus_wdata; gstage = 2;
                    end else begin
                        chk(!bus_we, "R6 poll is read", int'(bus_we), 0);
                        polls++;
                        if (polls > 1) chk(gap == TD, "R6 poll spacing", gap, TD);
                        bus_rdata = (polls < clear_after) ? (glb | 16'h8000) : (glb & 16'h7FFF);
                    end
                end else begin
                    chk(0, "R2 address decode", int'(bus_dev), 0);
                end
                last_ack_t = ncyc;
            end
        end
    end

    function automatic void last_ack_t_prev();
    endfunction

    function automatic int exp_status(input int eff, input int clr, input int err);
        int reads;
        reads = (clr < PMAX) ? clr : PMAX;
        if (err > 0 && err <= 2*eff + 2 + reads) return 2;
        if (clr <= PMAX) return 0;
        return 1;
    endfunction

    task automatic run_seq(input int cnt, input int clr, input int err, input int l,
                           input bit restart);
        int k, es, t0, got;
        cur_eff = (cnt > NPORT) ? NPORT : cnt;
        for (int i = 0; i < 16; i++) begin
            preg[i] = 16'($urandom); pinit[i] = preg[i];
        end
        glb = 16'($urandom) & 16'h7FFF; ginit = glb;
        clear_after = clr; err_at = err; lat = l;
        txn_n = 0; gstage = 0; polls = 0; exp_port = 0; exp_pwe = 0;
        es = exp_status(cur_eff, clr, err);
        @(negedge clk);
        port_count = 4'(cnt); start = 1;
        @(negedge clk);
        start = 0;
        chk(busy == 1'b1, "R9 busy after start", int'(busy), 1);
        k = 0;
        while (!done && k < 30000) begin
            @(negedge clk);
            k++;
            start = (restart && k == 20);
            if (restart && k == 20) port_count = 4'd3;
        end
        start = 0;
        if (!done) begin
            chk(0, "R9 done never seen", 0, 1);
            return;
        end
        got = int'(status);
        chk(got == es, "R6/R7/R8 status", got, es);
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
        t0 = txn_n;
        repeat (20) @(negedge clk);
        chk(txn_n == t0 && !busy, "R1/R8 no activity after done", txn_n - t0, 0);
        for (int i = 0; i < NPORT; i++) begin
            bit modf;
            logic [15:0] ev;
            modf = (i < cur_eff) && (err == 0 || err > 2*i + 2);
            ev = modf ? (pinit[i] & 16'hFFFC) : pinit[i];
            chk(preg[i] == ev, (i >= cur_eff) ? "R3 port untouched" : "R2/R8 port final",
                int'(preg[i]), int'(ev));
        end
        if (err == 0)
            chk(polls == ((clr < PMAX) ? clr : PMAX), "R6/R7 poll count", polls,
                (clr < PMAX) ? clr : PMAX);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #(20 * 190000);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; start = 0; port_count = 0; bus_ack = 0; bus_err = 0; bus_rdata = 0;
        lat = 0; err_at = 0; clear_after = 1; cur_eff = 0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !bus_req, "R10 reset state", int'({busy, done, bus_req}), 0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done && !bus_req, "R10 idle after reset", int'({busy, done, bus_req}), 0);

        run_seq(7, 3, 0, 1, 0);        // R2 basic
        run_seq(11, 1, 0, 0, 0);       // R6 immediate clear
        run_seq(0, 2, 0, 2, 0);        // R3 zero ports
        run_seq(15, 2, 0, 1, 0);       // R3 clamp
        run_seq(7, 1000, 0, 0, 0);     // R6 clears on last allowed poll
        run_seq(11, 1001, 0, 0, 0);    // R7 timeout
        run_seq(7, 5, 1, 1, 0);        // R8 first read
        run_seq(7, 5, 6, 0, 0);        // R8 mid port write
        run_seq(11, 5, 24, 2, 0);      // R8 trigger write
        run_seq(7, 5, 19, 1, 0);       // R8 third poll
        run_seq(7, 4, 0, 1, 1);        // R1 restart ignored
        for (int r = 0; r < 8; r++) begin
            int c, cl, e, l;
            c  = ($urandom % 2) ? 11 : 7;
            cl = 1 + int'($urandom % 30);
            l  = int'($urandom % 4);
            e  = ($urandom % 4 == 0) ? 1 + int'($urandom % (2*c + 2 + cl)) : 0;
            run_seq(c, cl, e, l, 0);
        end
        finish_run();
    end
endmodule